// File: doc/BRIEF.md
# Pipeline Hazard Interlock and Operand Forwarding Control

This block is the hazard-control logic for an in-order, five-stage load-store processor. It is purely combinational. Each cycle it looks at the instruction class and source fields of the instruction in decode, and at the class and register fields of the instructions in the execute, memory and writeback stages. For every one of those later stages it works out which register will be written and whether the write actually happens. It also works out which of its two source fields the decode instruction really uses.

From this it drives two forwarding selects, one for each source operand, and one stall request. The youngest in-flight writer of a source always wins. A source that the execute stage is about to produce with an ALU result is taken straight from the execute stage. A value that only exists later, such as load data or a link address, stalls decode while its producer is in execute. A branch resolved as taken in execute makes the decode instruction dead, so in that case no stall is requested.

A parameter selects a plain-interlock variant with no forwarding. In that variant, any match against a live writer in any later stage stalls decode. The register file, ALU and pipeline registers belong to the surrounding datapath.

Top module: `hz_ctrl`

## Requirements
- R1: Instruction class codes (4 bits) are 0 none, 1 register-register ALU, 2 ALU-immediate, 3 load, 4 store, 5 branch-if-zero, 6 branch-if-nonzero, 7 jump, 8 jump-and-link, 9 jump-register, 10 jump-register-and-link; codes 11 to 15 behave as class 0. The register written is rd for class 1, rt for classes 2 and 3, and register 31 for classes 8 and 10.
- R2: Classes 1, 2 and 3 write only when their destination is not register 0; classes 8 and 10 always write; no other class writes. A non-writing stage never causes a stall or a nonzero select.
- R3: The rs field is read by classes 1, 2, 3, 4, 5, 6, 9 and 10; the rt field is read only by classes 1 and 4. An unread field never causes a stall or a nonzero select.
- R4: Select encoding per operand is 0 register file, 1 execute, 2 memory, 3 writeback. A read source that matches the destination of a writing class 1 or 2 instruction in execute gets select 1.
- R5: A read source whose youngest writing match is in memory gets select 2, or in writeback gets select 3, whatever the writing class.
- R6: Only the youngest matching stage counts, in the order execute, then memory, then writeback. If that stage is execute holding class 3, 8 or 10, the select is 0.
- R7: With forwarding, stall is 1 exactly when a read source matches a writing class 3, 8 or 10 destination in execute. Matches in memory or writeback never stall.
- R8: Stall is 0 whenever execute holds class 5 with the zero flag set or class 6 with the zero flag clear. The opposite flag values do not cancel the stall.
- R9: With forwarding disabled, both selects are 0. Stall is 1 when any read source matches a writing destination in execute, memory or writeback, except as R8 says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_op | input | 4 | Class of the decode instruction |
| dec_rs | input | 5 | rs field in decode |
| dec_rt | input | 5 | rt field in decode |
| ex_op | input | 4 | Class of the execute instruction |
| ex_rt | input | 5 | rt field in execute |
| ex_rd | input | 5 | rd field in execute |
| ex_zero | input | 1 | Zero test of the execute branch operand |
| mem_op | input | 4 | Class of the memory-stage instruction |
| mem_rt | input | 5 | rt field in memory stage |
| mem_rd | input | 5 | rd field in memory stage |
| wb_op | input | 4 | Class of the writeback instruction |
| wb_rt | input | 5 | rt field in writeback |
| wb_rd | input | 5 | rd field in writeback |
| stall | output | 1 | Hold decode and fetch, inject a bubble |
| sel_a | output | 2 | Forwarding select for the rs operand |
| sel_b | output | 2 | Forwarding select for the rt operand |

## Verification
The hardest case to reach is the cancelled stall. With forwarding on, the only stall producer is a load or link jump sitting in execute, and a branch can never sit there at the same time. So the branch override cannot be seen on the forwarding build. The bench therefore also instantiates the plain-interlock variant. It parks a load in the memory stage behind a branch in execute and toggles the zero flag against both branch senses. Priority is driven by loading the same destination into two or three stages at once, including a stall-only writer in execute in front of a forwardable one. A long stretch of random stages with register fields drawn from a small set keeps matches frequent.

// File: rtl/hz_pkg.sv
package hz_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NONE  = 4'd0,
      OP_ALU   = 4'd1,
      OP_ALUI  = 4'd2,
      OP_LOAD  = 4'd3,
      OP_STORE = 4'd4,
      OP_BRZ   = 4'd5,
      OP_BRNZ  = 4'd6,
      OP_JMP   = 4'd7,
      OP_JMPL  = 4'd8,
      OP_JREG  = 4'd9,
      OP_JREGL = 4'd10
   } hz_op_e;

   typedef enum logic [1:0] {
      SRC_RF  = 2'd0,
      SRC_EX  = 2'd1,
      SRC_MEM = 2'd2,
      SRC_WB  = 2'd3
   } hz_sel_e;
endpackage

// File: rtl/hz_dest_decode.sv
module hz_dest_decode
   import hz_pkg::*;
#(
   parameter int REG_AW   = 5,
   parameter int LINK_REG = 31,
   parameter bit LATE     = 1'b0
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [REG_AW-1:0] rt_i,
   input  logic [REG_AW-1:0] rd_i,
   output logic [REG_AW-1:0] ws_o,
   output logic              we_o,
   output logic              fwd_o
);
   localparam logic [REG_AW-1:0] LINK = REG_AW'(LINK_REG);

   hz_op_e op;
   logic   writes;
   logic   alu_class;

   always_comb begin
      op        = hz_op_e'(op_i);
      ws_o      = '0;
      writes    = 1'b0;
      alu_class = 1'b0;
      case (op)
         OP_ALU:           begin ws_o = rd_i; writes = 1'b1; alu_class = 1'b1; end
         OP_ALUI:          begin ws_o = rt_i; writes = 1'b1; alu_class = 1'b1; end
         OP_LOAD:          begin ws_o = rt_i; writes = 1'b1; end
         OP_JMPL, OP_JREGL: begin ws_o = LINK; writes = 1'b1; end
         default:          ;
      endcase
      we_o = writes && (ws_o != '0);
   end

   generate
      if (LATE) begin : g_late
         assign fwd_o = we_o;
      end else begin : g_early
         assign fwd_o = we_o && alu_class;
      end
   endgenerate
endmodule

// File: rtl/hz_src_decode.sv
module hz_src_decode
   import hz_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   output logic            re_rs_o,
   output logic            re_rt_o
);
   hz_op_e op;

   always_comb begin
      op = hz_op_e'(op_i);
      case (op)
         OP_ALU, OP_STORE: begin re_rs_o = 1'b1; re_rt_o = 1'b1; end
         OP_ALUI, OP_LOAD, OP_BRZ, OP_BRNZ, OP_JREG, OP_JREGL:
                           begin re_rs_o = 1'b1; re_rt_o = 1'b0; end
         default:          begin re_rs_o = 1'b0; re_rt_o = 1'b0; end
      endcase
   end
endmodule

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
   import hz_pkg::*;
#(
   parameter int REG_AW      = 5,
   parameter int NSTG        = 3,
   parameter bit FULL_BYPASS = 1'b1
) (
   input  logic [REG_AW-1:0]            src_i,
   input  logic                         re_i,
   input  logic [NSTG-1:0][REG_AW-1:0]  ws_i,
   input  logic [NSTG-1:0]              we_i,
   input  logic [NSTG-1:0]              fwd_i,
   output logic [1:0]                   sel_o,
   output logic                         wait_o
);
   logic [NSTG-1:0] hit;

   for (genvar k = 0; k < NSTG; k++) begin : g_hit
      assign hit[k] = re_i && we_i[k] && (ws_i[k] == src_i);
   end

   generate
      if (FULL_BYPASS) begin : g_full
         always_comb begin
            sel_o  = SRC_RF;
            wait_o = 1'b0;
            for (int k = NSTG - 1; k >= 0; k--) begin
               if (hit[k]) begin
                  sel_o  = fwd_i[k] ? 2'(k + 1) : SRC_RF;
                  wait_o = !fwd_i[k];
               end
            end
         end
      end else begin : g_basic
         logic unused_fwd;
         assign unused_fwd = ^fwd_i;
         assign sel_o      = SRC_RF;
         assign wait_o     = |hit;
      end
   endgenerate
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
   import hz_pkg::*;
#(
   parameter int REG_AW      = 5,
   parameter int LINK_REG    = 31,
   parameter bit FULL_BYPASS = 1'b1
) (
   input  logic [3:0]        dec_op,
   input  logic [REG_AW-1:0] dec_rs,
   input  logic [REG_AW-1:0] dec_rt,
   input  logic [3:0]        ex_op,
   input  logic [REG_AW-1:0] ex_rt,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_zero,
   input  logic [3:0]        mem_op,
   input  logic [REG_AW-1:0] mem_rt,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic [3:0]        wb_op,
   input  logic [REG_AW-1:0] wb_rt,
   input  logic [REG_AW-1:0] wb_rd,
   output logic              stall,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b
);
   localparam int NSTG = 3;
   localparam int NOPD = 2;

   generate
      if (LINK_REG <= 0 || LINK_REG >= (1 << REG_AW)) begin : g_bad_link
         $error("hz_ctrl: LINK_REG out of register range");
      end
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("hz_ctrl: REG_AW out of supported range");
      end
   endgenerate

   logic [NSTG-1:0][OP_W-1:0]   stg_op;
   logic [NSTG-1:0][REG_AW-1:0] stg_rt, stg_rd, stg_ws;
   logic [NSTG-1:0]             stg_we, stg_fwd;

   assign stg_op = {wb_op, mem_op, ex_op};
   assign stg_rt = {wb_rt, mem_rt, ex_rt};
   assign stg_rd = {wb_rd, mem_rd, ex_rd};

   for (genvar k = 0; k < NSTG; k++) begin : g_stage
      hz_dest_decode #(
         .REG_AW(REG_AW), .LINK_REG(LINK_REG), .LATE(k != 0)
      ) u_dest (
         .op_i(stg_op[k]), .rt_i(stg_rt[k]), .rd_i(stg_rd[k]),
         .ws_o(stg_ws[k]), .we_o(stg_we[k]), .fwd_o(stg_fwd[k])
      );
   end

   logic re_rs, re_rt;
   hz_src_decode u_src (.op_i(dec_op), .re_rs_o(re_rs), .re_rt_o(re_rt));

   logic [NOPD-1:0][REG_AW-1:0] opd_src;
   logic [NOPD-1:0]             opd_re, opd_wait;
   logic [NOPD-1:0][1:0]        opd_sel;

   assign opd_src = {dec_rt, dec_rs};
   assign opd_re  = {re_rt, re_rs};

   for (genvar j = 0; j < NOPD; j++) begin : g_opd
      hz_fwd_select #(
         .REG_AW(REG_AW), .NSTG(NSTG), .FULL_BYPASS(FULL_BYPASS)
      ) u_sel (
         .src_i(opd_src[j]), .re_i(opd_re[j]),
         .ws_i(stg_ws), .we_i(stg_we), .fwd_i(stg_fwd),
         .sel_o(opd_sel[j]), .wait_o(opd_wait[j])
      );
   end

   hz_op_e ex_cls;
   logic   br_taken;

   always_comb begin
      ex_cls   = hz_op_e'(ex_op);
      br_taken = ((ex_cls == OP_BRZ) && ex_zero) || ((ex_cls == OP_BRNZ) && !ex_zero);
   end

   assign stall = (|opd_wait) && !br_taken;
   assign sel_a = opd_sel[0];
   assign sel_b = opd_sel[1];
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
   parameter int REG_AW      = 5,
   parameter bit FULL_BYPASS = 1'b1
) (
   input logic [3:0]        dec_op,
   input logic [REG_AW-1:0] dec_rs,
   input logic [REG_AW-1:0] dec_rt,
   input logic [3:0]        ex_op,
   input logic              ex_zero,
   input logic              stall,
   input logic [1:0]        sel_a,
   input logic [1:0]        sel_b
);
   logic known;
   assign known = !$isunknown({dec_op, dec_rs, dec_rt, ex_op, ex_zero, stall, sel_a, sel_b});

   always_comb begin
      if (known) begin
         if ((ex_op == 4'd5 && ex_zero) || (ex_op == 4'd6 && !ex_zero))
            p_taken_no_stall_r8: assert (!stall);
         if (FULL_BYPASS && stall)
            p_stall_needs_late_writer_r7: assert (ex_op == 4'd3 || ex_op == 4'd8 || ex_op == 4'd10);
         if (sel_a == 2'd1 || sel_b == 2'd1)
            p_ex_select_alu_r4: assert (ex_op == 4'd1 || ex_op == 4'd2);
         if (dec_op == 4'd0 || dec_op == 4'd7 || dec_op == 4'd8 || dec_op > 4'd10)
            p_rs_unread_r3: assert (sel_a == 2'd0);
         if (dec_op != 4'd1 && dec_op != 4'd4)
            p_rt_unread_r3: assert (sel_b == 2'd0);
         if (dec_rs == '0)
            p_zero_src_r2: assert (sel_a == 2'd0);
         if (!FULL_BYPASS)
            p_no_select_r9: assert (sel_a == 2'd0 && sel_b == 2'd0);
      end
   end
endmodule

bind hz_ctrl hz_ctrl_chk #(.REG_AW(REG_AW), .FULL_BYPASS(FULL_BYPASS)) u_hz_chk (
   .dec_op(dec_op), .dec_rs(dec_rs), .dec_rt(dec_rt),
   .ex_op(ex_op), .ex_zero(ex_zero),
   .stall(stall), .sel_a(sel_a), .sel_b(sel_b)
);

// File: tb/test_hz_ctrl.sv
`timescale 1ns/1ps
module test_hz_ctrl;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [3:0] dec_op, ex_op, mem_op, wb_op;
   logic [4:0] dec_rs, dec_rt, ex_rt, ex_rd, mem_rt, mem_rd, wb_rt, wb_rd;
   logic       ex_zero;
   logic       f_stall, b_stall;
   logic [1:0] f_sa, f_sb, b_sa, b_sb;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   hz_ctrl i_hz_ctrl (
      .dec_op(dec_op), .dec_rs(dec_rs), .dec_rt(dec_rt),
      .ex_op(ex_op), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_zero(ex_zero),
      .mem_op(mem_op), .mem_rt(mem_rt), .mem_rd(mem_rd),
      .wb_op(wb_op), .wb_rt(wb_rt), .wb_rd(wb_rd),
      .stall(f_stall), .sel_a(f_sa), .sel_b(f_sb)
   );

   hz_ctrl #(.FULL_BYPASS(1'b0)) i_hz_ctrl_basic (
      .dec_op(dec_op), .dec_rs(dec_rs), .dec_rt(dec_rt),
      .ex_op(ex_op), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_zero(ex_zero),
      .mem_op(mem_op), .mem_rt(mem_rt), .mem_rd(mem_rd),
      .wb_op(wb_op), .wb_rt(wb_rt), .wb_rd(wb_rd),
      .stall(b_stall), .sel_a(b_sa), .sel_b(b_sb)
   );

   task automatic chk(input string req, input string what, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   // Reference: destination and write for one stage, from the class table
   function automatic void ref_dest(input int op, input int rt, input int rd,
                                    output int dst, output bit wr, output bit late_only);
      dst = 0; wr = 0; late_only = 0;
      if (op == 1) begin dst = rd; wr = (rd != 0); end
      else if (op == 2) begin dst = rt; wr = (rt != 0); end
      else if (op == 3) begin dst = rt; wr = (rt != 0); late_only = 1; end
      else if (op == 8 || op == 10) begin dst = 31; wr = 1; late_only = 1; end
   endfunction

   function automatic void ref_model(input bit full, output int st, output int sa, output int sb);
      int ops[3], rts[3], rds[3];
      int srcs[2];
      bit reads[2];
      int sels[2];
      bit hold = 0;
      bit kill;
      ops[0] = ex_op;  rts[0] = ex_rt;  rds[0] = ex_rd;
      ops[1] = mem_op; rts[1] = mem_rt; rds[1] = mem_rd;
      ops[2] = wb_op;  rts[2] = wb_rt;  rds[2] = wb_rd;
      srcs[0] = dec_rs; srcs[1] = dec_rt;
      reads[0] = (dec_op >= 1 && dec_op <= 6) || dec_op == 9 || dec_op == 10;
      reads[1] = (dec_op == 1 || dec_op == 4);
      foreach (srcs[j]) begin
         bit found = 0;
         sels[j] = 0;
         for (int s = 0; s < 3; s++) begin
            int d; bit w, lo;
            ref_dest(ops[s], rts[s], rds[s], d, w, lo);
            if (!found && reads[j] && w && d == srcs[j]) begin
               found = 1;
               if (!full) hold = 1;
               else if (s == 0 && lo) hold = 1;
               else sels[j] = s + 1;
            end
         end
      end
      kill = (ex_op == 5 && ex_zero) || (ex_op == 6 && !ex_zero);
      st = (hold && !kill) ? 1 : 0;
      sa = sels[0]; sb = sels[1];
   endfunction

   task automatic clear_all();
      dec_op = 0; dec_rs = 0; dec_rt = 0;
      ex_op = 0; ex_rt = 0; ex_rd = 0; ex_zero = 0;
      mem_op = 0; mem_rt = 0; mem_rd = 0;
      wb_op = 0; wb_rt = 0; wb_rd = 0;
   endtask

   task automatic expect_full(input string req, input int st, input int sa, input int sb);
      #5;
      chk(req, "stall", int'(f_stall), st);
      chk(req, "sel_a", int'(f_sa), sa);
      chk(req, "sel_b", int'(f_sb), sb);
   endtask

   task automatic expect_basic(input string req, input int st);
      #5;
      chk(req, "basic stall", int'(b_stall), st);
      chk(req, "basic sel_a", int'(b_sa), 0);
      chk(req, "basic sel_b", int'(b_sb), 0);
   endtask

   initial begin
      clear_all();
      // R1: idle pipeline gives no stall and register-file selects
      @(negedge clk); expect_full("R1", 0, 0, 0);

      // R4: ALU writing rd=3 in execute, decode ALU reads rs=3, rt=3
      @(negedge clk); clear_all();
      ex_op = 1; ex_rd = 3; ex_rt = 9; dec_op = 1; dec_rs = 3; dec_rt = 3;
      expect_full("R4", 0, 1, 1);

      // R1: ALU-immediate writes rt, not rd
      @(negedge clk); clear_all();
      ex_op = 2; ex_rt = 4; ex_rd = 9; dec_op = 2; dec_rs = 9;
      expect_full("R1", 0, 0, 0);
      @(negedge clk); dec_rs = 4;
      expect_full("R1", 0, 1, 0);

      // R2: destination 0 never matches; store never writes
      @(negedge clk); clear_all();
      ex_op = 1; ex_rd = 0; dec_op = 1; dec_rs = 0; dec_rt = 0;
      expect_full("R2", 0, 0, 0);
      @(negedge clk); clear_all();
      ex_op = 4; ex_rt = 5; ex_rd = 5; dec_op = 1; dec_rs = 5;
      expect_full("R2", 0, 0, 0);

      // R7: load in execute stalls; R5: load in memory forwards
      @(negedge clk); clear_all();
      ex_op = 3; ex_rt = 7; dec_op = 1; dec_rs = 7;
      expect_full("R7", 1, 0, 0);
      @(negedge clk); clear_all();
      mem_op = 3; mem_rt = 7; dec_op = 1; dec_rs = 7;
      expect_full("R5", 0, 2, 0);

      // R7: link jump in execute stalls a jump-register on r31
      @(negedge clk); clear_all();
      ex_op = 8; dec_op = 9; dec_rs = 31;
      expect_full("R7", 1, 0, 0);
      // R5: link jump in writeback forwards r31 from writeback
      @(negedge clk); clear_all();
      wb_op = 10; dec_op = 10; dec_rs = 31;
      expect_full("R5", 0, 3, 0);

      // R6: priority across stages
      @(negedge clk); clear_all();
      ex_op = 1; ex_rd = 2; mem_op = 1; mem_rd = 2; wb_op = 1; wb_rd = 2;
      dec_op = 1; dec_rs = 2; dec_rt = 2;
      expect_full("R6", 0, 1, 1);
      @(negedge clk); ex_op = 0;
      expect_full("R6", 0, 2, 2);
      @(negedge clk); mem_op = 4;
      expect_full("R6", 0, 3, 3);
      @(negedge clk); ex_op = 3; ex_rt = 2; mem_op = 1;
      expect_full("R6", 1, 0, 0);

      // R3: rt unread by ALU-immediate, read by store; rs unread by jump
      @(negedge clk); clear_all();
      ex_op = 1; ex_rd = 6; dec_op = 2; dec_rs = 1; dec_rt = 6;
      expect_full("R3", 0, 0, 0);
      @(negedge clk); dec_op = 4;
      expect_full("R3", 0, 0, 1);
      @(negedge clk); dec_op = 7; dec_rs = 6;
      expect_full("R3", 0, 0, 0);
      @(negedge clk); dec_op = 13; dec_rs = 6; dec_rt = 6;
      expect_full("R1", 0, 0, 0);

      // R9: plain interlock stalls on a memory-stage match
      @(negedge clk); clear_all();
      mem_op = 3; mem_rt = 7; dec_op = 1; dec_rt = 7;
      expect_basic("R9", 1);
      @(negedge clk); mem_op = 0; wb_op = 1; wb_rd = 7;
      expect_basic("R9", 1);

      // R8: taken branch in execute cancels the stall, not-taken keeps it
      @(negedge clk); clear_all();
      mem_op = 3; mem_rt = 7; dec_op = 1; dec_rs = 7;
      ex_op = 5; ex_zero = 1;
      expect_basic("R8", 0);
      @(negedge clk); ex_zero = 0;
      expect_basic("R8", 1);
      @(negedge clk); ex_op = 6; ex_zero = 0;
      expect_basic("R8", 0);
      @(negedge clk); ex_zero = 1;
      expect_basic("R8", 1);

      // Random stage contents compared with the reference each clock
      for (int n = 0; n < 3000; n++) begin
         int st, sa, sb;
         @(negedge clk);
         dec_op = 4'($urandom_range(0, 12));
         ex_op  = 4'($urandom_range(0, 11));
         mem_op = 4'($urandom_range(0, 11));
         wb_op  = 4'($urandom_range(0, 11));
         dec_rs = ($urandom_range(0, 9) == 0) ? 5'd31 : 5'($urandom_range(0, 3));
         dec_rt = 5'($urandom_range(0, 3));
         ex_rt  = 5'($urandom_range(0, 3));  ex_rd  = 5'($urandom_range(0, 3));
         mem_rt = 5'($urandom_range(0, 3)); mem_rd = 5'($urandom_range(0, 3));
         wb_rt  = 5'($urandom_range(0, 3));  wb_rd  = 5'($urandom_range(0, 3));
         ex_zero = 1'($urandom_range(0, 1));
         #5;
         ref_model(1'b1, st, sa, sb);
         chk("R7", "random stall", int'(f_stall), st);
         chk("R6", "random sel_a", int'(f_sa), sa);
         chk("R6", "random sel_b", int'(f_sb), sb);
         ref_model(1'b0, st, sa, sb);
         chk("R9", "random basic stall", int'(b_stall), st);
         chk("R9", "random basic sel_a", int'(b_sa), sa);
         chk("R9", "random basic sel_b", int'(b_sb), sb);
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule